// File: doc/BRIEF.md
# Local interrupt controller base and mode register

This block holds the 64-bit base register of a local interrupt controller and the mode state machine behind it. The controller runs in one of three modes: disabled, xAPIC or x2APIC. Software writes a full 64-bit value with a one-cycle strobe. The block checks that value against the current mode and against a static input that says whether the extended (x2) mode exists.

If the write is illegal, the block raises a fault pulse in the same cycle and keeps its state. If the write is legal, the block loads the base address and the mode bits. It also performs the side effects of a mode change: it drops or raises the feature-visible enable flag, clears the software-enable bit of the spurious-vector state, and derives a cluster-style logical destination when x2 mode is entered.

The block also holds the controller ID. Every base-register write that gets past the reserved-bit check puts the ID back to its initial value, so an ID changed by software does not survive a mode change.

Top module: `lapic_mode_reg`

## Requirements
- R1: After reset the register reads as the default base 0xFEE00 in bits 31:12, with enable (bit 11) at 1, extended (bit 10) at 0 and bit 8 equal to the strap input. After reset the mode is xAPIC, the feature flag is 1, the ID equals the initial ID, the logical destination is 0, the spurious software-enable bit is 0 and fault is 0.
- R2: A legal write loads bits 31:12 of the written value into the base field. Bit 8 keeps its old value whatever was written to it. All bits of the read value other than 31:12, 11, 10 and 8 read as 0.
- R3: A write with any bit set in 63:32, in 9 or in 7:0 is a fault. The register, the mode and the controller ID all stay unchanged.
- R4: A write with bit 10 set while the extended mode is not supported is a fault, and the state stays unchanged.
- R5: A write with bit 10 at 1 and bit 11 at 0 is a fault, whatever the current mode.
- R6: From disabled mode, a write with bit 11 at 1 and bit 10 at 1 is a fault.
- R7: From x2APIC mode, a write with bit 11 at 1 and bit 10 at 0 is a fault. A write with both bits at 0 is legal and leads to disabled mode.
- R8: A legal write with bit 11 at 0 gives disabled mode (mode 2'b00), clears the feature flag and clears the spurious software-enable bit. A legal write with bit 11 at 1 from disabled mode gives xAPIC mode (2'b01) with the feature flag set. A legal write with bits 11 and 10 both at 1 gives x2APIC mode (2'b10).
- R9: A legal write into x2APIC mode sets the logical destination to ((initialId & 0xFFFF0) << 16) | (1 << (initialId & 0xF)), kept to 32 bits.
- R10: Every write strobe that passes the reserved-bit check puts the controller ID back to the initial ID. This includes writes that then fault on a mode rule. An ID write and a base write in the same cycle resolve in favour of the base write.
- R11: fault is high only in a cycle where the write strobe is high and the write is illegal. The read value in the following cycle equals its value in the fault cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bspStrap | input | 1 | Reset value of the bootstrap-processor bit |
| x2Supported | input | 1 | Static: extended mode is available |
| initialId | input | ID_W | Initial controller ID |
| wrEn | input | 1 | Base-register write strobe |
| wrData | input | 64 | Value written to the base register |
| idWrEn | input | 1 | Software write of the controller ID |
| idWrData | input | ID_W | New controller ID |
| svWrEn | input | 1 | Write of the spurious software-enable bit |
| svWrBit | input | 1 | New spurious software-enable value |
| fault | output | 1 | Same-cycle pulse marking a rejected write |
| rdData | output | 64 | Readable register value |
| mode | output | 2 | 00 disabled, 01 xAPIC, 10 x2APIC |
| featureEn | output | 1 | Feature-visible enable flag |
| ctrlId | output | ID_W | Current controller ID |
| logicalDest | output | 32 | Derived logical destination |
| svSwEnable | output | 1 | Spurious software-enable bit |

## Verification
The bench walks the mode machine along every legal edge and tries each forbidden edge from the state where it applies. Each forbidden edge is a jump from disabled to x2APIC, a fall from x2APIC back to xAPIC, extended without enable, and extended while unsupported. A checker that missed one of these would let the mode output change where it must hold, with no fault pulse.

Reserved-bit writes are tried with a software-modified ID. A design that reset the ID before the reserved check would lose the modified value, while one that skipped the reset on mode-rule faults would keep a stale ID. The bench also writes a base value with the bootstrap bit flipped, which shows whether that bit is wrongly taken from the write. Finally it checks the logical destination against a value worked out from the initial ID.

// File: rtl/lapic_mode_pkg.sv
package lapic_mode_pkg;
  localparam int BSP_BIT = 8;
  localparam int EXT_BIT = 10;
  localparam int EN_BIT  = 11;
  localparam int BASE_LO = 12;
  localparam int BASE_HI = 31;
  localparam int BASE_W  = BASE_HI - BASE_LO + 1;
  localparam int LD_W    = 32;
  // bits that software may write without a fault
  localparam logic [63:0] KEEP_MASK = 64'h0000_0000_FFFF_FD00;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_XAPIC = 2'b01,
    MODE_X2    = 2'b10
  } mode_e;

  typedef struct packed {
    logic loadBase;
    logic resetId;
    logic nextEn;
    logic nextExt;
  } ctrl_s;
endpackage

// File: rtl/lapic_mode_ctrl.sv
module lapic_mode_ctrl
  import lapic_mode_pkg::*;
(
  input  logic        wrEn,
  input  logic [63:0] wrData,
  input  logic        x2Supported,
  input  logic        curEn,
  input  logic        curExt,
  output logic        fault,
  output ctrl_s       strb
);
  logic rsvdHit, badExt, badCombo, badJump, badBack, illegal;
  logic wEn, wExt;

  always_comb begin
    wEn      = wrData[EN_BIT];
    wExt     = wrData[EXT_BIT];
    rsvdHit  = |(wrData & ~KEEP_MASK);
    badExt   = wExt && !x2Supported;
    badCombo = wExt && !wEn;
    badJump  = !curEn && !curExt && wEn && wExt;
    badBack  = curEn && curExt && wEn && !wExt;
    illegal  = rsvdHit || badExt || badCombo || badJump || badBack;
    fault         = wrEn && illegal;
    strb.loadBase = wrEn && !illegal;
    strb.resetId  = wrEn && !rsvdHit;
    strb.nextEn   = wEn;
    strb.nextExt  = wExt;
  end
endmodule

// File: rtl/lapic_mode_dp.sv
module lapic_mode_dp
  import lapic_mode_pkg::*;
#(
  parameter int ID_W = 32,
  parameter logic [BASE_W-1:0] BASE_RST = 20'hFEE00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bspStrap,
  input  logic [ID_W-1:0]   initialId,
  input  logic [BASE_W-1:0] wrBase,
  input  ctrl_s             strb,
  input  logic              idWrEn,
  input  logic [ID_W-1:0]   idWrData,
  input  logic              svWrEn,
  input  logic              svWrBit,
  output logic              curEn,
  output logic              curExt,
  output logic [63:0]       rdData,
  output logic              featureEn,
  output logic [ID_W-1:0]   ctrlId,
  output logic [LD_W-1:0]   logicalDest,
  output logic              svSwEnable
);
  logic [BASE_W-1:0] baseQ;
  logic              enQ, extQ, bspQ, featQ, svQ;
  logic [ID_W-1:0]   idQ;
  logic [LD_W-1:0]   ldQ, ldNext;

  // cluster in the upper half, one-hot member in the low 16 bits
  always_comb ldNext = {initialId[15:4], 20'b0} | (LD_W'(1) << initialId[3:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= BASE_RST;
      enQ   <= 1'b1;
      extQ  <= 1'b0;
      bspQ  <= bspStrap;
      featQ <= 1'b1;
      svQ   <= 1'b0;
      idQ   <= initialId;
      ldQ   <= '0;
    end else begin
      if (strb.loadBase) begin
        baseQ <= wrBase;
        enQ   <= strb.nextEn;
        extQ  <= strb.nextExt;
        featQ <= strb.nextEn;
        if (strb.nextExt) ldQ <= ldNext;
      end
      if (strb.loadBase && !strb.nextEn) svQ <= 1'b0;
      else if (svWrEn)                   svQ <= svWrBit;
      if (strb.resetId)  idQ <= initialId;
      else if (idWrEn)   idQ <= idWrData;
    end
  end

  always_comb begin
    curEn       = enQ;
    curExt      = extQ;
    rdData      = {32'b0, baseQ, enQ, extQ, 1'b0, bspQ, 8'b0};
    featureEn   = featQ;
    ctrlId      = idQ;
    logicalDest = ldQ;
    svSwEnable  = svQ;
  end
endmodule

// File: rtl/lapic_mode_reg.sv
module lapic_mode_reg
  import lapic_mode_pkg::*;
#(
  parameter int ID_W = 32,
  parameter logic [19:0] BASE_RST = 20'hFEE00
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            bspStrap,
  input  logic            x2Supported,
  input  logic [ID_W-1:0] initialId,
  input  logic            wrEn,
  input  logic [63:0]     wrData,
  input  logic            idWrEn,
  input  logic [ID_W-1:0] idWrData,
  input  logic            svWrEn,
  input  logic            svWrBit,
  output logic            fault,
  output logic [63:0]     rdData,
  output logic [1:0]      mode,
  output logic            featureEn,
  output logic [ID_W-1:0] ctrlId,
  output logic [31:0]     logicalDest,
  output logic            svSwEnable
);
  ctrl_s strb;
  logic  curEn, curExt;

  lapic_mode_ctrl i_ctrl (
    .wrEn(wrEn), .wrData(wrData), .x2Supported(x2Supported),
    .curEn(curEn), .curExt(curExt), .fault(fault), .strb(strb)
  );

  lapic_mode_dp #(.ID_W(ID_W), .BASE_RST(BASE_RST)) i_dp (
    .clk(clk), .rstN(rstN), .bspStrap(bspStrap), .initialId(initialId),
    .wrBase(wrData[BASE_HI:BASE_LO]), .strb(strb),
    .idWrEn(idWrEn), .idWrData(idWrData), .svWrEn(svWrEn), .svWrBit(svWrBit),
    .curEn(curEn), .curExt(curExt), .rdData(rdData), .featureEn(featureEn),
    .ctrlId(ctrlId), .logicalDest(logicalDest), .svSwEnable(svSwEnable)
  );

  always_comb begin
    if (!curEn)     mode = MODE_OFF;
    else if (curExt) mode = MODE_X2;
    else            mode = MODE_XAPIC;
  end
endmodule

// File: rtl/lapic_mode_chk.sv
module lapic_mode_chk
  import lapic_mode_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        fault,
  input logic [63:0] rdData,
  input logic [1:0]  mode,
  input logic        featureEn,
  input logic [19:0] idLow,
  input logic [31:0] logicalDest
);
  logic [63:0] ldWide;
  always_comb ldWide = ((64'(idLow) & 64'hFFFF0) << 16) | (64'd1 << idLow[3:0]);

  p_fault_needs_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> wrEn);
  p_fault_holds_state_r11: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> $stable(rdData));
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~KEEP_MASK) == 64'd0);
  p_no_ext_without_en_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdData[EXT_BIT] |-> rdData[EN_BIT]);
  p_no_jump_to_x2_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF) |=> (mode != MODE_X2));
  p_no_fall_to_xapic_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_X2) |=> (mode != MODE_XAPIC));
  p_feature_tracks_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    featureEn == (mode != MODE_OFF));
  p_ldest_in_x2_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_X2) |-> (logicalDest == ldWide[31:0]));
endmodule

bind lapic_mode_reg lapic_mode_chk i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .fault(fault), .rdData(rdData),
  .mode(mode), .featureEn(featureEn), .idLow(initialId[19:0]),
  .logicalDest(logicalDest)
);

// File: tb/test_lapic_mode_reg.sv
module test_lapic_mode_reg;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] INIT_ID = 32'h0000_0A37;

  logic clk = 1'b0, rstN = 1'b0, bspStrap = 1'b1, x2Supported = 1'b0;
  logic wrEn = 1'b0, idWrEn = 1'b0, svWrEn = 1'b0, svWrBit = 1'b0;
  logic [63:0] wrData = '0;
  logic [31:0] idWrData = '0;
  logic fault, featureEn, svSwEnable;
  logic [63:0] rdData;
  logic [1:0] mode;
  logic [31:0] ctrlId, logicalDest;
  int nTests = 0, nFail = 0;
  bit done = 0;
  logic lastFault;

  always #(CLK_PERIOD/2) clk = ~clk;

  lapic_mode_reg i_lapic_mode_reg (
    .clk(clk), .rstN(rstN), .bspStrap(bspStrap), .x2Supported(x2Supported),
    .initialId(INIT_ID), .wrEn(wrEn), .wrData(wrData), .idWrEn(idWrEn),
    .idWrData(idWrData), .svWrEn(svWrEn), .svWrBit(svWrBit), .fault(fault),
    .rdData(rdData), .mode(mode), .featureEn(featureEn), .ctrlId(ctrlId),
    .logicalDest(logicalDest), .svSwEnable(svSwEnable)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive a write for one cycle; the fault is sampled inside that cycle
  task automatic doWrite(input logic [63:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    #1 lastFault = fault;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
    #1;
  endtask

  task automatic setId(input logic [31:0] v);
    @(negedge clk); idWrEn = 1'b1; idWrData = v;
    @(negedge clk); idWrEn = 1'b0; #1;
  endtask

  task automatic setSv(input logic v);
    @(negedge clk); svWrEn = 1'b1; svWrBit = v;
    @(negedge clk); svWrEn = 1'b0; #1;
  endtask

  task automatic tReset();
    chk("R1 rdData", rdData, 64'h0000_0000_FEE0_0900);
    chk("R1 mode", 64'(mode), 64'd1);
    chk("R1 featureEn", 64'(featureEn), 64'd1);
    chk("R1 ctrlId", 64'(ctrlId), 64'(INIT_ID));
    chk("R1 logicalDest", 64'(logicalDest), 64'd0);
    chk("R1 svSwEnable", 64'(svSwEnable), 64'd0);
    chk("R11 idle fault", 64'(fault), 64'd0);
  endtask

  task automatic tBaseMove();
    doWrite(64'h0000_0000_ABCD_E800);  // bit 8 written 0, must stay 1
    chk("R2 fault", 64'(lastFault), 64'd0);
    chk("R2 rdData", rdData, 64'h0000_0000_ABCD_E900);
    chk("R2 mode", 64'(mode), 64'd1);
  endtask

  task automatic tReserved();
    setId(32'h55);
    doWrite(64'h0000_0001_1234_5800);
    chk("R3 fault hi", 64'(lastFault), 64'd1);
    chk("R3 rdData", rdData, 64'h0000_0000_ABCD_E900);
    chk("R3 id kept", 64'(ctrlId), 64'h55);
    doWrite(64'h0000_0000_1234_5A00);  // bit 9
    chk("R3 fault b9", 64'(lastFault), 64'd1);
    doWrite(64'h0000_0000_1234_5801);  // bit 0
    chk("R3 fault b0", 64'(lastFault), 64'd1);
    chk("R3 rdData2", rdData, 64'h0000_0000_ABCD_E900);
    chk("R3 id kept2", 64'(ctrlId), 64'h55);
  endtask

  task automatic tUnsupported();
    x2Supported = 1'b0;
    doWrite(64'h0000_0000_ABCD_EC00);
    chk("R4 fault", 64'(lastFault), 64'd1);
    chk("R4 mode", 64'(mode), 64'd1);
    chk("R10 id reset on mode fault", 64'(ctrlId), 64'(INIT_ID));
    chk("R11 fault drops", 64'(fault), 64'd0);
  endtask

  task automatic tCombo();
    x2Supported = 1'b1;
    doWrite(64'h0000_0000_ABCD_E400);
    chk("R5 fault", 64'(lastFault), 64'd1);
    chk("R5 rdData", rdData, 64'h0000_0000_ABCD_E900);
  endtask

  task automatic tEnterX2();
    logic [63:0] ld;
    ld = ((64'(INIT_ID) & 64'hFFFF0) << 16) | (64'd1 << (INIT_ID & 32'hF));
    setId(32'h77);
    doWrite(64'h0000_0000_ABCD_EC00);
    chk("R8 x2 fault", 64'(lastFault), 64'd0);
    chk("R8 x2 mode", 64'(mode), 64'd2);
    chk("R9 logicalDest", 64'(logicalDest), {32'd0, ld[31:0]});
    chk("R10 id reset", 64'(ctrlId), 64'(INIT_ID));
    chk("R2 rdData x2", rdData, 64'h0000_0000_ABCD_ED00);
  endtask

  task automatic tFallBack();
    doWrite(64'h0000_0000_ABCD_E800);
    chk("R7 fault", 64'(lastFault), 64'd1);
    chk("R7 mode held", 64'(mode), 64'd2);
  endtask

  task automatic tDisable();
    setSv(1'b1);
    chk("R8 sv set", 64'(svSwEnable), 64'd1);
    doWrite(64'h0000_0000_1234_5000);
    chk("R7 disable legal", 64'(lastFault), 64'd0);
    chk("R8 mode off", 64'(mode), 64'd0);
    chk("R8 featureEn off", 64'(featureEn), 64'd0);
    chk("R8 sv cleared", 64'(svSwEnable), 64'd0);
    chk("R2 rdData off", rdData, 64'h0000_0000_1234_5100);
  endtask

  task automatic tJump();
    doWrite(64'h0000_0000_1234_5C00);
    chk("R6 fault", 64'(lastFault), 64'd1);
    chk("R6 mode held", 64'(mode), 64'd0);
  endtask

  task automatic tReenable();
    doWrite(64'h0000_0000_FEE0_0800);
    chk("R8 reenable fault", 64'(lastFault), 64'd0);
    chk("R8 reenable mode", 64'(mode), 64'd1);
    chk("R8 featureEn on", 64'(featureEn), 64'd1);
  endtask

  task automatic tSameCycle();
    @(negedge clk); idWrEn = 1'b1; idWrData = 32'h99;
    wrEn = 1'b1; wrData = 64'h0000_0000_FEE0_0800;
    @(negedge clk); idWrEn = 1'b0; wrEn = 1'b0; wrData = '0; #1;
    chk("R10 base write wins", 64'(ctrlId), 64'(INIT_ID));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    tReset();
    tBaseMove();
    tReserved();
    tUnsupported();
    tCombo();
    tEnterX2();
    tFallBack();
    tDisable();
    tJump();
    tReenable();
    tSameCycle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nTests++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule